// File: doc/BRIEF.md
# Parallel FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA through its parallel configuration port. A single start pulse, together with a byte count, starts a full handshake. The block first selects the target for writing and gives it a program pulse of fixed length. It then waits for the target's init line to go high. Next it takes payload bytes from a ready/valid byte stream, packs them into bus-width words and clocks each word into the target with a divided configuration clock.

After the last word the block checks that init is still high and polls the done line, giving up after a bounded number of polls. When done is seen it issues a fixed number of extra clock pulses with a zero data bus, so that the target can finish its start-up. Busy covers the whole run. At the end either a finished flag or an error code is left standing until the next start.

Top module: `pcfg_seq`

## Requirements
- R1: After reset, and whenever busy is low, prog_n, csel_n and rdwr_n are high, cfg_clk is low, finished is 0 and err_code is 0 (after reset).
- R2: An accepted start gives one cycle with prog_n high and csel_n/rdwr_n low. Then prog_n is low for exactly CLK_HZ/1000*PROG_MS cycles while csel_n and rdwr_n stay low.
- R3: No cfg_clk pulse occurs before init_i has been seen high after the program pulse. The block waits at that point for as long as init_i stays low.
- R4: Payload bytes are accepted only when in_ready and in_valid are both high. Each group of BUS_BYTES bytes forms one word, with the first byte in the most significant lane. A short final word is padded with zero bytes in the low lanes. Each word gives exactly one rising edge of cfg_clk.
- R5: cfg_data is placed at least one cycle before the rising edge of cfg_clk that carries it. cfg_clk has a period of CLK_DIV cycles, low for the first CLK_DIV/2 of them.
- R6: If BUS_BYTES is not 1, 2 or 4, a start sets err_code to 1 and leaves busy low, with no change on any port control pin or on cfg_clk.
- R7: If init_i is low in the cycle after the last word's clock period, the run ends with err_code 2 and busy low.
- R8: If done_i stays low for MAX_POLLS consecutive polls, the run ends with err_code 3.
- R9: Once done_i is seen high, exactly TAIL_CLKS further cfg_clk pulses are issued with cfg_data zero. After them, finished is set and err_code is 0.
- R10: busy is high from an accepted start until the run ends. A start while busy is ignored.
- R11: A length of zero skips the data phase and goes straight from the init wait to the init check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a configuration run |
| length | input | 32 | Payload size in bytes, sampled at start |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is present |
| in_ready | output | 1 | Block accepts a payload byte |
| init_i | input | 1 | Target init status (high = ready / no error) |
| done_i | input | 1 | Target done status |
| prog_n | output | 1 | Active-low program pulse to target |
| csel_n | output | 1 | Active-low chip select to target |
| rdwr_n | output | 1 | Read/write select, low for write |
| cfg_data | output | 8*BUS_BYTES | Configuration data bus |
| cfg_clk | output | 1 | Configuration clock |
| busy | output | 1 | Run in progress |
| finished | output | 1 | Last run completed successfully |
| err_code | output | 2 | 0 none, 1 bad width, 2 init low after load, 3 done timeout |

## Verification
The main instance is built with CLK_HZ of 1000 and PROG_MS of 20, so the program pulse lasts 20 cycles and its exact length can be compared cycle by cycle. It uses MAX_POLLS of 16, which brings the done timeout within a short run, and CLK_DIV of 4 with two-byte words, so the word packing, zero padding and stalled streams are all exercised. A second instance with BUS_BYTES of 3 is used only to show that a width the block does not support is rejected.

// File: rtl/pcfg_seq.sv
module pcfg_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PROG_MS   = 20,
  parameter int BUS_BYTES = 2,
  parameter int CLK_DIV   = 4,
  parameter int MAX_POLLS = 1000,
  parameter int TAIL_CLKS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            length,
  input  logic [7:0]             in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   init_i,
  input  logic                   done_i,
  output logic                   prog_n,
  output logic                   csel_n,
  output logic                   rdwr_n,
  output logic [8*BUS_BYTES-1:0] cfg_data,
  output logic                   cfg_clk,
  output logic                   busy,
  output logic                   finished,
  output logic [1:0]             err_code
);
  localparam int DW       = 8 * BUS_BYTES;
  localparam int PROG_CYC = CLK_HZ / 1000 * PROG_MS;
  localparam int LOWC     = CLK_DIV / 2;
  localparam bit WIDTH_OK = (BUS_BYTES == 1) || (BUS_BYTES == 2) || (BUS_BYTES == 4);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_PULSE, S_WINIT, S_LOAD, S_SEND, S_CHECK, S_POLL, S_TAIL
  } st_t;

  st_t         state;
  logic [31:0] cnt, rem;
  logic [15:0] lane;
  logic [DW-1:0] word;
  logic        take;

  assign busy     = state != S_IDLE;
  assign prog_n   = state != S_PULSE;
  assign csel_n   = state == S_IDLE;
  assign rdwr_n   = state == S_IDLE;
  assign cfg_clk  = (state == S_SEND || state == S_TAIL) && cnt >= 32'(LOWC);
  assign in_ready = state == S_LOAD && rem != 0;
  assign take     = state == S_LOAD && (rem == 0 || in_valid);
  assign cfg_data = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      rem      <= '0;
      lane     <= '0;
      word     <= '0;
      finished <= 1'b0;
      err_code <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          finished <= 1'b0;
          word     <= '0;
          if (!WIDTH_OK) err_code <= 2'd1;
          else begin
            err_code <= 2'd0;
            rem      <= length;
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt   <= '0;
          state <= S_PULSE;
        end
        S_PULSE:
          if (cnt == 32'(PROG_CYC - 1)) begin
            cnt   <= '0;
            state <= S_WINIT;
          end else cnt <= cnt + 1;
        S_WINIT: if (init_i) begin
          lane  <= '0;
          state <= (rem == 0) ? S_CHECK : S_LOAD;
        end
        S_LOAD: if (take) begin
          word <= (rem != 0) ? ((word << 8) | DW'(in_data)) : (word << 8);
          if (rem != 0) rem <= rem - 1;
          if (lane == 16'(BUS_BYTES - 1)) begin
            lane  <= '0;
            cnt   <= '0;
            state <= S_SEND;
          end else lane <= lane + 1;
        end
        S_SEND:
          if (cnt == 32'(CLK_DIV - 1)) begin
            cnt   <= '0;
            state <= (rem == 0) ? S_CHECK : S_LOAD;
          end else cnt <= cnt + 1;
        S_CHECK:
          if (!init_i) begin
            err_code <= 2'd2;
            state    <= S_IDLE;
          end else begin
            cnt   <= '0;
            state <= S_POLL;
          end
        S_POLL:
          if (done_i) begin
            cnt   <= '0;
            lane  <= '0;
            word  <= '0;
            state <= S_TAIL;
          end else if (cnt == 32'(MAX_POLLS - 1)) begin
            err_code <= 2'd3;
            state    <= S_IDLE;
          end else cnt <= cnt + 1;
        S_TAIL:
          if (cnt == 32'(CLK_DIV - 1)) begin
            cnt <= '0;
            if (lane == 16'(TAIL_CLKS - 1)) begin
              finished <= 1'b1;
              state    <= S_IDLE;
            end else lane <= lane + 1;
          end else cnt <= cnt + 1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcfg_seq_chk.sv
module pcfg_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          prog_n,
  input logic          csel_n,
  input logic          rdwr_n,
  input logic [DW-1:0] cfg_data,
  input logic          cfg_clk,
  input logic          busy,
  input logic          finished,
  input logic [1:0]    err_code
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && csel_n && rdwr_n && !cfg_clk));

  p_pulse_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!csel_n && !rdwr_n));

  p_no_clk_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !cfg_clk);

  p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> !cfg_clk);

  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_data));

  p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  p_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (finished != (err_code != 2'd0)));

  p_fin_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> err_code == 2'd0);
endmodule

bind pcfg_seq pcfg_seq_chk #(.DW(8 * BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .prog_n(prog_n),
  .csel_n(csel_n), .rdwr_n(rdwr_n), .cfg_data(cfg_data), .cfg_clk(cfg_clk),
  .busy(busy), .finished(finished), .err_code(err_code)
);

// File: tb/sim_pcfg_seq.sv
`timescale 1ns/1ps
module sim_pcfg_seq;
  localparam int CLKHZ = 1000, PMS = 20, BB = 2, DIV = 4, POLLS = 16, TAIL = 8;
  localparam int PCYC = CLKHZ / 1000 * PMS;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, init_i = 0, done_i = 0;
  logic [31:0] length = 0;
  logic [7:0] in_data;
  logic in_ready, prog_n, csel_n, rdwr_n, cfg_clk, busy, finished;
  logic [15:0] cfg_data;
  logic [1:0] err_code;

  logic start1 = 0;
  logic in_ready1, prog_n1, csel_n1, rdwr_n1, cfg_clk1, busy1, finished1;
  logic [23:0] cfg_data1;
  logic [1:0] err_code1;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:63];
  int idx = 0, nbytes = 0;
  bit stall = 0, ven = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign in_data = (idx < nbytes) ? mem[idx] : 8'h00;

  pcfg_seq #(.CLK_HZ(CLKHZ), .PROG_MS(PMS), .BUS_BYTES(BB), .CLK_DIV(DIV),
             .MAX_POLLS(POLLS), .TAIL_CLKS(TAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .length(length), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .init_i(init_i), .done_i(done_i),
    .prog_n(prog_n), .csel_n(csel_n), .rdwr_n(rdwr_n), .cfg_data(cfg_data),
    .cfg_clk(cfg_clk), .busy(busy), .finished(finished), .err_code(err_code));

  pcfg_seq #(.CLK_HZ(CLKHZ), .PROG_MS(PMS), .BUS_BYTES(3), .CLK_DIV(DIV),
             .MAX_POLLS(POLLS), .TAIL_CLKS(TAIL)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .length(32'd4), .in_data(8'h00),
    .in_valid(1'b0), .in_ready(in_ready1), .init_i(1'b1), .done_i(1'b1),
    .prog_n(prog_n1), .csel_n(csel_n1), .rdwr_n(rdwr_n1), .cfg_data(cfg_data1),
    .cfg_clk(cfg_clk1), .busy(busy1), .finished(finished1), .err_code(err_code1));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase names as integers
  // 0 idle 1 setup 2 pulse 3 wait-init 4 gather 5 clock-out 6 init-check 7 poll 8 tail
  int ph = 0, pc = 0, rem = 0, lanes = 0, tails = 0;
  logic [15:0] mw = 0;
  bit mfin = 0;
  int merr = 0;

  always @(negedge clk) begin
    cyc++;
    in_valid <= ven && (!stall || (cyc % 3 != 0));
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; pc = 0; rem = 0; lanes = 0; tails = 0; mw = 0; mfin = 0; merr = 0;
    end else begin
      case (ph)
        0: if (start) begin
             mfin = 0; merr = 0; mw = 0; rem = int'(length); ph = 1;
           end
        1: begin pc = 0; ph = 2; end
        2: begin pc++; if (pc == PCYC) begin pc = 0; ph = 3; end end
        3: if (init_i) begin lanes = 0; ph = (rem == 0) ? 6 : 4; end
        4: if (rem == 0 || in_valid) begin
             mw = {mw[7:0], (rem == 0) ? 8'h00 : in_data};
             if (rem != 0) begin rem--; idx <= idx + 1; end
             lanes++;
             if (lanes == BB) begin lanes = 0; pc = 0; ph = 5; end
           end
        5: begin pc++; if (pc == DIV) begin pc = 0; ph = (rem == 0) ? 6 : 4; end end
        6: if (!init_i) begin merr = 2; ph = 0; end else begin pc = 0; ph = 7; end
        7: if (done_i) begin pc = 0; tails = 0; mw = 0; ph = 8; end
           else begin pc++; if (pc == POLLS) begin merr = 3; ph = 0; end end
        8: begin pc++;
             if (pc == DIV) begin
               pc = 0; tails++;
               if (tails == TAIL) begin mfin = 1; ph = 0; end
             end
           end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(prog_n === (ph != 2), "R2 prog_n", prog_n, ph != 2);
      check(csel_n === (ph == 0), "R2 csel_n", csel_n, ph == 0);
      check(rdwr_n === (ph == 0), "R2 rdwr_n", rdwr_n, ph == 0);
      check(cfg_clk === ((ph == 5 || ph == 8) && pc >= DIV / 2), "R5 cfg_clk", cfg_clk,
            (ph == 5 || ph == 8) && pc >= DIV / 2);
      check(cfg_data === mw, "R4 cfg_data", cfg_data, mw);
      check(in_ready === (ph == 4 && rem != 0), "R4 in_ready", in_ready, ph == 4 && rem != 0);
      check(busy === (ph != 0), "R10 busy", busy, ph != 0);
      check(finished === mfin, "R9 finished", finished, mfin);
      check(err_code === 2'(merr), "R7 err_code", err_code, merr);
    end
  end

  // rising-edge capture on the configuration clock
  int rises = 0;
  logic [15:0] cap [0:63];
  logic pclk = 0;
  always @(negedge clk) begin
    if (cfg_clk && !pclk) begin
      if (rises < 64) cap[rises] = cfg_data;
      rises++;
    end
    pclk = cfg_clk;
  end

  task automatic pulse_start(input int n);
    @(negedge clk);
    length = n;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic load_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) mem[i] = 8'(seed + 17 * i);
    nbytes = n;
    idx = 0;
  endtask

  task automatic check_words(input int n, input string req);
    int w;
    logic [15:0] e;
    w = (n + BB - 1) / BB;
    check(rises == w + TAIL, {req, " clock count"}, rises, w + TAIL);
    for (int k = 0; k < w; k++) begin
      e = {mem[2 * k], (2 * k + 1 < n) ? mem[2 * k + 1] : 8'h00};
      check(cap[k] === e, {req, " packed word"}, cap[k], e);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(prog_n && csel_n && rdwr_n && !cfg_clk && !busy, "R1 pins after reset",
          {prog_n, csel_n, rdwr_n, cfg_clk, busy}, 5'b11100);
    check(!finished && err_code == 0, "R1 flags after reset", {finished, err_code}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // normal run, six bytes, init late, done at once (R2 R3 R4 R9)
    load_bytes(6, 8'h31); ven = 1; stall = 0; init_i = 0; done_i = 1; rises = 0;
    pulse_start(6);
    repeat (PCYC + 8) @(negedge clk);
    check(rises == 0, "R3 no clock before init", rises, 0);
    init_i = 1;
    wait_idle();
    check_words(6, "R4");
    check(finished && err_code == 0, "R9 finished", {finished, err_code}, 3'b100);

    // odd count with stalls, plus start while busy (R4 R10)
    load_bytes(5, 8'hA2); stall = 1; rises = 0;
    pulse_start(5);
    repeat (5) @(negedge clk);
    pulse_start(9);
    wait_idle();
    check_words(5, "R10 ignored start");
    check(idx == 5, "R4 bytes consumed", idx, 5);

    // zero length (R11)
    load_bytes(0, 0); rises = 0;
    pulse_start(0);
    wait_idle();
    check(rises == TAIL, "R11 only tail clocks", rises, TAIL);
    check(finished, "R11 finished", finished, 1);

    // init low after load (R7)
    load_bytes(4, 8'h5C); stall = 0; rises = 0;
    pulse_start(4);
    for (int i = 0; i < 200 && rises == 0; i++) @(negedge clk);
    init_i = 0;
    wait_idle();
    check(err_code == 2 && !finished, "R7 init error", err_code, 2);
    check(rises == 2, "R7 no tail clocks", rises, 2);
    init_i = 1;

    // done never rises (R8)
    load_bytes(2, 8'h77); done_i = 0; rises = 0;
    pulse_start(2);
    wait_idle();
    check(err_code == 3 && !finished, "R8 timeout error", err_code, 3);
    check(rises == 1, "R8 no tail clocks", rises, 1);
    done_i = 1;

    // unsupported width (R6)
    @(negedge clk); start1 = 1; @(negedge clk); start1 = 0;
    repeat (3) @(negedge clk);
    check(err_code1 == 1, "R6 width error", err_code1, 1);
    check(!busy1 && prog_n1 && csel_n1 && rdwr_n1 && !cfg_clk1 && !in_ready1,
          "R6 no pin activity", {busy1, prog_n1, csel_n1, rdwr_n1, cfg_clk1}, 5'b01110);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule